// File: doc/BRIEF.md
# Ethernet Receive Flow Controller

This block decides when the local station should push back on its Ethernet link partner. It makes the decision from the fill level of the receive queue, compared against a high watermark. In full duplex it asks the transmit side for pause frames and supplies the pause time each frame should carry. In half duplex it can instead force a jam sequence onto frames that are arriving from the partner. The assembly of pause frames and the MAC transmit path belong to other blocks.

A small configuration port holds the mode settings: automatic flow control, manual jam, and the pause time. While automatic flow control holds off a full-duplex partner, the block refreshes the pause request at half of the pause interval. When the queue drains, it sends one zero-time request so that the partner can resume early.

Manual jam behaves in two ways, depending on the queue level:
- With the queue below the watermark, enabling jam marks exactly one later frame for jamming.
- While the queue sits at or above the watermark, every new frame is jammed.

Top module: `rx_flow_ctrl`

## Requirements
- R1: After reset, automatic flow control is on, manual jam is off, the pause time register holds PTIME_RST, and `pause_req_o`, `jam_active_o` and `jam_strb_o` are low.
- R2: With full duplex and automatic flow control on, the queue is "high" when `fill_level_i >= high_mark_i`. The first clock edge at which the queue is high raises `pause_req_o` for one cycle, and `pause_time_o` then equals the programmed pause time.
- R3: When full duplex is off or automatic flow control is off, no pause request carries a nonzero time, and a high queue alone raises no request.
- R4: While the queue stays high, the pause request repeats every H cycles, where H = (pause_time * QUANTUM_CYC) / 2. An H of zero means a repeat every cycle.
- R5: At the first edge after the queue leaves the high state (or flow control stops applying) while a pause is held, exactly one request is issued with `pause_time_o` = 0.
- R6: A jam starts only when all three hold: full duplex is off, automatic flow control is off, and manual jam is enabled. With automatic flow control on, the jam-enable bit has no effect.
- R7: A jam raises `jam_active_o` at the edge that takes the start-of-frame strobe. `jam_strb_o` = `jam_active_o` AND `byte_tick_i`, and the jam ends after JAM_BYTES (4) such strobes.
- R8: Writing the jam-enable bit from 0 to 1 arms a single jam. If the queue is below the watermark, only the next frame is jammed and the frames after it are not.
- R9: While the queue is high and jam is allowed, every frame is jammed. Frames that start after the queue drops below the watermark are not jammed.
- R10: A jam starts only on a `sof_i` received outside a frame, where a frame runs from `sof_i` to `eof_i`. A further `sof_i` inside the same frame never starts or restarts a jam.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fill_level_i | input | LEVEL_W | Current receive queue fill level |
| high_mark_i | input | LEVEL_W | High watermark |
| full_duplex_i | input | 1 | 1 = full duplex, 0 = half duplex |
| cfg_we_i | input | 1 | Writes the three configuration fields below |
| cfg_auto_fc_i | input | 1 | Automatic flow control enable (write data) |
| cfg_jam_en_i | input | 1 | Manual jam enable (write data) |
| cfg_pause_time_i | input | PTIME_W | Pause time in quanta (write data) |
| sof_i | input | 1 | Receive start-of-frame strobe |
| eof_i | input | 1 | Receive end-of-frame strobe |
| byte_tick_i | input | 1 | One pulse per received byte time |
| pause_req_o | output | 1 | One-cycle pause frame request |
| pause_time_o | output | PTIME_W | Pause time for the request |
| jam_active_o | output | 1 | Jam sequence in progress |
| jam_strb_o | output | 1 | Byte strobe of the jam sequence |

## Verification
Pause behaviour is driven by holding the queue high long enough to see several refreshes, and then dropping it. This separates the initial request, the refresh interval, the single zero-time resume and a stale controller that keeps pausing. The test is repeated with a reprogrammed pause time, which shows that the interval follows the register and not a constant. Jam is tried in three situations: with a low queue after arming, with a sustained high queue over consecutive frames, and with each gating bit wrong. Together these separate one-shot from continuous jamming, show that gating and duplex are respected, and show that a repeated start strobe inside a frame is ignored.

// File: rtl/rx_fc_pkg.sv
package rx_fc_pkg;
  typedef enum logic [0:0] {
    PS_IDLE = 1'b0,
    PS_HOLD = 1'b1
  } pause_state_e;

  localparam int unsigned JAM_BYTES = 4;
endpackage

// File: rtl/rx_fc_pause.sv
module rx_fc_pause
  import rx_fc_pkg::*;
#(
  parameter int unsigned PTIME_W     = 16,
  parameter int unsigned QUANTUM_CYC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               active_i,
  input  logic               high_i,
  input  logic [PTIME_W-1:0] ptime_i,
  output logic               req_o,
  output logic [PTIME_W-1:0] time_o
);
  localparam int unsigned Q_W   = (QUANTUM_CYC > 1) ? $clog2(QUANTUM_CYC) + 1 : 1;
  localparam int unsigned TMR_W = PTIME_W + Q_W;

  pause_state_e state_q, state_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [TMR_W-1:0] half_ivl, reload;
  logic             req_d;
  logic [PTIME_W-1:0] time_d;

  always_comb begin
    half_ivl = (TMR_W'(ptime_i) * TMR_W'(QUANTUM_CYC)) >> 1;
    reload   = (half_ivl == '0) ? '0 : half_ivl - 1'b1;
  end

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    req_d   = 1'b0;
    time_d  = time_o;
    unique case (state_q)
      PS_IDLE: begin
        if (active_i && high_i) begin
          req_d   = 1'b1;
          time_d  = ptime_i;
          tmr_d   = reload;
          state_d = PS_HOLD;
        end
      end
      PS_HOLD: begin
        if (!(active_i && high_i)) begin
          // resume early
          req_d   = 1'b1;
          time_d  = '0;
          state_d = PS_IDLE;
        end else if (tmr_q == '0) begin
          req_d  = 1'b1;
          time_d = ptime_i;
          tmr_d  = reload;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_IDLE;
      tmr_q   <= '0;
      req_o   <= 1'b0;
      time_o  <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      req_o   <= req_d;
      time_o  <= time_d;
    end
  end
endmodule

// File: rtl/rx_fc_jam.sv
module rx_fc_jam
  import rx_fc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic allow_i,
  input  logic high_i,
  input  logic arm_i,
  input  logic disarm_i,
  input  logic sof_i,
  input  logic eof_i,
  input  logic byte_tick_i,
  output logic active_o,
  output logic strb_o
);
  localparam int unsigned CNT_W = $clog2(JAM_BYTES + 1);

  logic             in_frame_q;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start;

  assign start  = allow_i && sof_i && !in_frame_q && (high_i || armed_q);
  assign strb_o = active_o && byte_tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
    end else if (sof_i && !in_frame_q) begin
      in_frame_q <= 1'b1;
    end else if (eof_i) begin
      in_frame_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
    end else if (disarm_i || start) begin
      armed_q <= 1'b0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      cnt_q    <= '0;
    end else if (start && !active_o) begin
      active_o <= 1'b1;
      cnt_q    <= CNT_W'(JAM_BYTES);
    end else if (active_o && byte_tick_i) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) active_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_flow_ctrl.sv
module rx_flow_ctrl
  import rx_fc_pkg::*;
#(
  parameter int unsigned LEVEL_W     = 12,
  parameter int unsigned PTIME_W     = 16,
  parameter int unsigned QUANTUM_CYC = 4,
  parameter logic [PTIME_W-1:0] PTIME_RST = PTIME_W'(8)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LEVEL_W-1:0] fill_level_i,
  input  logic [LEVEL_W-1:0] high_mark_i,
  input  logic               full_duplex_i,
  input  logic               cfg_we_i,
  input  logic               cfg_auto_fc_i,
  input  logic               cfg_jam_en_i,
  input  logic [PTIME_W-1:0] cfg_pause_time_i,
  input  logic               sof_i,
  input  logic               eof_i,
  input  logic               byte_tick_i,
  output logic               pause_req_o,
  output logic [PTIME_W-1:0] pause_time_o,
  output logic               jam_active_o,
  output logic               jam_strb_o
);
  logic               auto_fc_q;
  logic               jam_en_q;
  logic [PTIME_W-1:0] pause_time_q;
  logic               q_high;
  logic               jam_allow;
  logic               jam_arm, jam_disarm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_fc_q    <= 1'b1;
      jam_en_q     <= 1'b0;
      pause_time_q <= PTIME_RST;
    end else if (cfg_we_i) begin
      auto_fc_q    <= cfg_auto_fc_i;
      jam_en_q     <= cfg_jam_en_i;
      pause_time_q <= cfg_pause_time_i;
    end
  end

  assign q_high     = fill_level_i >= high_mark_i;
  assign jam_allow  = !full_duplex_i && !auto_fc_q && jam_en_q;
  assign jam_arm    = cfg_we_i && cfg_jam_en_i && !jam_en_q;
  assign jam_disarm = cfg_we_i && !cfg_jam_en_i;

  rx_fc_pause #(
    .PTIME_W    (PTIME_W),
    .QUANTUM_CYC(QUANTUM_CYC)
  ) u_pause (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(full_duplex_i && auto_fc_q),
    .high_i  (q_high),
    .ptime_i (pause_time_q),
    .req_o   (pause_req_o),
    .time_o  (pause_time_o)
  );

  rx_fc_jam u_jam (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .allow_i    (jam_allow),
    .high_i     (q_high),
    .arm_i      (jam_arm),
    .disarm_i   (jam_disarm),
    .sof_i      (sof_i),
    .eof_i      (eof_i),
    .byte_tick_i(byte_tick_i),
    .active_o   (jam_active_o),
    .strb_o     (jam_strb_o)
  );
endmodule

// File: rtl/rx_flow_ctrl_chk.sv
module rx_flow_ctrl_chk #(
  parameter int unsigned LEVEL_W = 12,
  parameter int unsigned PTIME_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [LEVEL_W-1:0] fill_level_i,
  input logic [LEVEL_W-1:0] high_mark_i,
  input logic               full_duplex_i,
  input logic               auto_fc_q,
  input logic [PTIME_W-1:0] pause_time_q,
  input logic               sof_i,
  input logic               pause_req_o,
  input logic [PTIME_W-1:0] pause_time_o,
  input logic               jam_active_o,
  input logic               jam_strb_o
);
  // R3
  nonzero_pause_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_req_o && pause_time_o != '0) |-> $past(full_duplex_i && auto_fc_q));

  // R5
  zero_pause_on_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_req_o && pause_time_o == '0) |->
      $past(fill_level_i < high_mark_i || !full_duplex_i || !auto_fc_q || pause_time_q == '0));

  // R6
  jam_half_duplex_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(jam_active_o) |-> $past(!full_duplex_i && !auto_fc_q));

  // R10
  jam_needs_sof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(jam_active_o) |-> $past(sof_i));

  // R7
  jam_strb_inside_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jam_strb_o |-> jam_active_o);

  // R7
  jam_ends_on_strb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(jam_active_o) |-> $past(jam_strb_o));
endmodule

bind rx_flow_ctrl rx_flow_ctrl_chk #(
  .LEVEL_W(LEVEL_W),
  .PTIME_W(PTIME_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fill_level_i (fill_level_i),
  .high_mark_i  (high_mark_i),
  .full_duplex_i(full_duplex_i),
  .auto_fc_q    (auto_fc_q),
  .pause_time_q (pause_time_q),
  .sof_i        (sof_i),
  .pause_req_o  (pause_req_o),
  .pause_time_o (pause_time_o),
  .jam_active_o (jam_active_o),
  .jam_strb_o   (jam_strb_o)
);

// File: tb/rx_flow_ctrl_test.sv
module rx_flow_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 12;
  localparam int PW = 16;
  localparam int QC = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [LW-1:0] fill_level_i = '0;
  logic [LW-1:0] high_mark_i = LW'(64);
  logic          full_duplex_i = 1'b1;
  logic          cfg_we_i = 1'b0;
  logic          cfg_auto_fc_i = 1'b1;
  logic          cfg_jam_en_i = 1'b0;
  logic [PW-1:0] cfg_pause_time_i = '0;
  logic          sof_i = 1'b0;
  logic          eof_i = 1'b0;
  logic          byte_tick_i = 1'b1;
  logic          pause_req_o;
  logic [PW-1:0] pause_time_o;
  logic          jam_active_o;
  logic          jam_strb_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rx_flow_ctrl #(.LEVEL_W(LW), .PTIME_W(PW), .QUANTUM_CYC(QC), .PTIME_RST(PW'(8))) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .fill_level_i(fill_level_i), .high_mark_i(high_mark_i),
    .full_duplex_i(full_duplex_i), .cfg_we_i(cfg_we_i), .cfg_auto_fc_i(cfg_auto_fc_i),
    .cfg_jam_en_i(cfg_jam_en_i), .cfg_pause_time_i(cfg_pause_time_i), .sof_i(sof_i),
    .eof_i(eof_i), .byte_tick_i(byte_tick_i), .pause_req_o(pause_req_o),
    .pause_time_o(pause_time_o), .jam_active_o(jam_active_o), .jam_strb_o(jam_strb_o));

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic write_cfg(input logic af, input logic je, input int pt);
    cfg_we_i = 1'b1; cfg_auto_fc_i = af; cfg_jam_en_i = je; cfg_pause_time_i = PW'(pt);
    step();
    cfg_we_i = 1'b0;
  endtask

  // runs one frame with sof and returns the number of jam strobes seen
  task automatic frame(input bit extra_sof, output int strobes, output int started);
    strobes = 0; started = 0;
    sof_i = 1'b1;
    step();
    sof_i = 1'b0;
    if (jam_active_o) started = 1;
    for (int i = 0; i < 8; i++) begin
      if (jam_strb_o) strobes++;
      if (i == 5 && extra_sof) sof_i = 1'b1;
      step();
      sof_i = 1'b0;
    end
    if (jam_active_o) started++;
    eof_i = 1'b1;
    step();
    eof_i = 1'b0;
    step();
  endtask

  task automatic t_reset();
    check("R1", pause_req_o, 0, "pause_req after reset");
    check("R1", jam_active_o, 0, "jam_active after reset");
    check("R1", jam_strb_o, 0, "jam_strb after reset");
  endtask

  // reset configuration: auto on, pause time 8 -> H = 16
  task automatic t_pause_default();
    full_duplex_i = 1'b1; fill_level_i = LW'(64);
    step();
    check("R2", pause_req_o, 1, "first request at watermark");
    check("R1", pause_time_o, 8, "reset pause time");
    for (int i = 1; i < 16; i++) begin
      step();
      check("R4", pause_req_o, 0, "no early refresh");
    end
    step();
    check("R4", pause_req_o, 1, "refresh after 16 cycles");
    check("R4", pause_time_o, 8, "refresh time");
    fill_level_i = LW'(63);
    step();
    check("R5", pause_req_o, 1, "resume request");
    check("R5", pause_time_o, 0, "resume time zero");
    step();
    check("R5", pause_req_o, 0, "single resume");
  endtask

  // pause time 10 -> H = 20
  task automatic t_pause_programmed();
    write_cfg(1'b1, 1'b0, 10);
    fill_level_i = LW'(200);
    step();
    check("R2", pause_time_o, 10, "programmed pause time");
    for (int i = 1; i < 20; i++) step();
    check("R4", pause_req_o, 0, "cycle 19 quiet");
    step();
    check("R4", pause_req_o, 1, "refresh after 20 cycles");
    fill_level_i = LW'(0);
    step();
    check("R5", pause_time_o, 0, "resume after drain");
    step();
  endtask

  task automatic t_pause_gated();
    int seen;
    seen = 0;
    write_cfg(1'b0, 1'b0, 10);
    fill_level_i = LW'(200);
    for (int i = 0; i < 30; i++) begin step(); if (pause_req_o) seen++; end
    check("R3", seen, 0, "no request with auto off");
    write_cfg(1'b1, 1'b0, 10);
    full_duplex_i = 1'b0;
    seen = 0;
    for (int i = 0; i < 30; i++) begin step(); if (pause_req_o) seen++; end
    check("R3", seen, 0, "no request in half duplex");
    fill_level_i = LW'(0);
    step();
  endtask

  task automatic t_jam_gating();
    int s, st;
    full_duplex_i = 1'b0; fill_level_i = LW'(200);
    write_cfg(1'b1, 1'b1, 10);
    frame(1'b0, s, st);
    check("R6", st, 0, "no jam with auto flow on");
    write_cfg(1'b0, 1'b0, 10);
    frame(1'b0, s, st);
    check("R6", st, 0, "no jam without jam enable");
    full_duplex_i = 1'b1;
    write_cfg(1'b0, 1'b1, 10);
    frame(1'b0, s, st);
    check("R6", st, 0, "no jam in full duplex");
    write_cfg(1'b0, 1'b0, 10);
    full_duplex_i = 1'b0; fill_level_i = LW'(0);
  endtask

  task automatic t_jam_oneshot();
    int s, st;
    fill_level_i = LW'(10);
    write_cfg(1'b0, 1'b1, 10);
    frame(1'b0, s, st);
    check("R8", st, 1, "armed frame jammed");
    check("R7", s, 4, "jam strobe count");
    frame(1'b0, s, st);
    check("R8", st, 0, "second frame not jammed");
    frame(1'b0, s, st);
    check("R8", st, 0, "third frame not jammed");
  endtask

  task automatic t_jam_high();
    int s, st;
    fill_level_i = LW'(64);
    for (int f = 0; f < 3; f++) begin
      frame(1'b1, s, st);
      check("R9", st, 1, "frame jammed while high");
      check("R10", s, 4, "extra sof did not restart jam");
    end
    fill_level_i = LW'(63);
    frame(1'b0, s, st);
    check("R9", st, 0, "no jam after drain");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 1);
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_pause_default();
    t_pause_programmed();
    t_pause_gated();
    t_jam_gating();
    t_jam_oneshot();
    t_jam_high();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule